// File: doc/BRIEF.md
# Interrupt Aggregator with Pending Replay

This block merges a vector of interrupt source lines into a single level interrupt output. Firmware sees two 32-bit registers. The first is an enable register. Each write adds enables that stick until reset. Once no new enable bit is added, the same register toggles per-source mask bits, which the service routine uses to hold off sources while it runs. The second is a status register that reports which sources caused the current interrupt. Software clears it by writing ones to the bits it wants cleared.

A trigger is the rising edge of the OR of all enabled, asserted source lines. The selected set may overlap a masked source or a status bit that has not been acknowledged yet. In that case the set goes into a hidden pending vector, and status and the output stay as they are. When a normal acknowledge leaves status empty, the pending vector is moved into status and the output stays high. With nothing pending, the output drops. A write of all ones to status clears it without that replay step. Firmware uses this write to initialise the register.

Top module: `intagg_top`

## Requirements
- R1: After reset, the enable image, the status register, the mask, the pending vector and the interrupt output are all zero.
- R2: The selected set is source lines AND the enable vector. Only a rising edge of the OR of the selected set triggers evaluation. A held assertion is evaluated once, and lines that are not enabled cause no action.
- R3: An unblocked trigger overwrites status with the selected set, and the output is high one clock after the edge is sampled.
- R4: A trigger whose selected set overlaps the mask or the current status ORs the set into pending. Status and the output do not change.
- R5: Writing zero to the enable register while the enable vector is zero only stores zero as the image. The mask does not change.
- R6: An enable write sets the enable vector to the old vector OR the data. If that adds any bit, the data becomes the image and the mask is untouched. Enable bits are never lost before reset.
- R7: An enable write that adds no bit computes change = image XOR data. If change AND data is nonzero, the change bits are removed from the mask. Otherwise they are added to the mask. The data then becomes the image.
- R8: A status write of zero changes nothing.
- R9: A nonzero status write clears exactly the bits written as one.
- R10: A status write of all ones clears status. It leaves pending and the output as they were.
- R11: When any other nonzero status write leaves status at zero, a nonzero pending vector is copied into status and zeroed, and the output stays high. With pending zero, the output goes low. While the output is low, status is zero.
- R12: The enable image reads at byte offset 0 and status at byte offset 4. Accesses are whole words. Other offsets read zero, and writes to them are ignored.
- R13: When a trigger and a register write fall in the same clock, the blocking test uses the mask and status from the start of that clock. The trigger result overrides the status and output produced by the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Interrupt source lines, synchronous to clk |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte address, word aligned |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Aggregated interrupt level |

## Verification
The mask and the pending vector cannot be read, so any error in them shows up later at the ports. A wrong mask bit appears on the next rising edge of that source, which lands in status or fails to. A wrong pending bit stays hidden until the acknowledge that drains status to zero, and the status value read one clock after that write reveals it. A source that is evaluated again while held would add a stray pending bit, so a later replay brings it out. Because of this, the bench drains status after each scenario, and its random phase compares the status value and the output level after every single clock.

// File: rtl/intagg_pkg.sv
`timescale 1ns/1ps
package intagg_pkg;

    typedef enum logic [1:0] {
        SLOT_ENABLE = 2'd0,
        SLOT_STATUS = 2'd1,
        SLOT_NONE   = 2'd2
    } slot_e;

    // Word index 0 holds the enable image, word index 1 holds status.
    function automatic slot_e decode_slot(input int unsigned word_idx);
        if (word_idx == 0) begin
            return SLOT_ENABLE;
        end else if (word_idx == 1) begin
            return SLOT_STATUS;
        end
        return SLOT_NONE;
    endfunction

endpackage

// File: rtl/intagg_trigger.sv
`timescale 1ns/1ps
module intagg_trigger #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic               trig_o,
    output logic [NUM_SRC-1:0] sel_o
);

    typedef struct packed {
        logic any;
    } trig_st_t;

    trig_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        sel_o    = src_i & en_i;
        st_d.any = |sel_o;
        trig_o   = st_d.any & ~st_q.any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_BACK_TO_BACK_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o) else $error("trigger repeated"); // R2

endmodule

// File: rtl/intagg_enable_ctl.sv
`timescale 1ns/1ps
module intagg_enable_ctl #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] image_o,
    output logic [NUM_SRC-1:0] mask_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] img;
        logic [NUM_SRC-1:0] mask;
    } en_st_t;

    en_st_t st_d, st_q;
    logic [NUM_SRC-1:0] grown;
    logic [NUM_SRC-1:0] change;

    always_comb begin
        st_d   = st_q;
        grown  = st_q.en | wdata_i;
        change = st_q.img ^ wdata_i;
        if (wr_i) begin
            if ((wdata_i == '0) && (st_q.en == '0)) begin
                st_d.img = wdata_i;
            end else if (grown != st_q.en) begin
                st_d.en  = grown;
                st_d.img = wdata_i;
            end else begin
                if ((change & wdata_i) != '0) begin
                    st_d.mask = st_q.mask & ~change;
                end else begin
                    st_d.mask = st_q.mask | change;
                end
                st_d.img = wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o    = st_q.en;
    assign image_o = st_q.img;
    assign mask_o  = st_q.mask;

    AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.en & $past(st_q.en)) == $past(st_q.en))) else $error("enable lost"); // R6
    AST_ZERO_WRITE_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (wdata_i == '0) && (st_q.en == '0)) |=> $stable(st_q.mask)) else $error("mask moved"); // R5
    AST_GROW_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && ((st_q.en | wdata_i) != st_q.en)) |=> $stable(st_q.mask)) else $error("mask moved on grow"); // R6

endmodule

// File: rtl/intagg_status_eng.sv
`timescale 1ns/1ps
module intagg_status_eng #(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               trig_i,
    input  logic [NUM_SRC-1:0] sel_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic               irq_o
);

    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [NUM_SRC-1:0] pending;
        logic               irq;
    } stat_st_t;

    stat_st_t st_d, st_q;
    logic [NUM_SRC-1:0] clr_bits;
    logic               blocked;

    always_comb begin
        st_d     = st_q;
        clr_bits = wdata_i[NUM_SRC-1:0];
        blocked  = ((sel_i & (mask_i | st_q.status)) != '0);
        if (clr_i && (wdata_i != '0)) begin
            st_d.status = st_q.status & ~clr_bits;
            if ((wdata_i != ALL_ONES) && (st_d.status == '0)) begin
                if (st_q.pending != '0) begin
                    st_d.status  = st_q.pending;
                    st_d.pending = '0;
                    st_d.irq     = 1'b1;
                end else begin
                    st_d.irq = 1'b0;
                end
            end
        end
        if (trig_i) begin
            if (blocked) begin
                st_d.pending = st_d.pending | sel_i;
            end else begin
                st_d.status = sel_i;
                st_d.irq    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign irq_o    = st_q.irq;

    AST_IRQ_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> (st_q.status != '0)) else $error("irq without status"); // R3
    AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((st_q.pending & $past(st_q.pending)) == $past(st_q.pending))) else $error("pending lost"); // R4
    AST_ZERO_CLEAR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (wdata_i == '0) && !trig_i) |=> ($stable(st_q.status) && $stable(st_q.irq))) else $error("zero write acted"); // R8
    AST_ALL_ONES_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (wdata_i == ALL_ONES) && !trig_i) |=> ($stable(st_q.irq) && (st_q.status == '0))) else $error("all-ones write acted"); // R10
    AST_IDLE_STATUS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.irq |-> (st_q.status == '0)) else $error("status set while idle"); // R11

endmodule

// File: rtl/intagg_top.sv
`timescale 1ns/1ps
module intagg_top #(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o
);
    import intagg_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    slot_e              slot;
    logic               en_wr;
    logic               st_wr;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] en_img;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] sel;
    logic               trig;
    logic [DATA_W-1:0]  img_ext;
    logic [DATA_W-1:0]  status_ext;

    always_comb begin
        slot  = decode_slot(int'(bus_addr_i[ADDR_W-1:2]));
        en_wr = bus_wr_i && (slot == SLOT_ENABLE);
        st_wr = bus_wr_i && (slot == SLOT_STATUS);
    end

    intagg_trigger #(.NUM_SRC(NUM_SRC)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .en_i   (en_vec),
        .trig_o (trig),
        .sel_o  (sel)
    );

    intagg_enable_ctl #(.NUM_SRC(NUM_SRC)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (en_wr),
        .wdata_i (bus_wdata_i[NUM_SRC-1:0]),
        .en_o    (en_vec),
        .image_o (en_img),
        .mask_o  (mask)
    );

    intagg_status_eng #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (st_wr),
        .wdata_i  (bus_wdata_i),
        .trig_i   (trig),
        .sel_i    (sel),
        .mask_i   (mask),
        .status_o (status),
        .irq_o    (irq_o)
    );

    generate
        if (NUM_SRC < DATA_W) begin : g_pad
            assign img_ext    = {{(DATA_W-NUM_SRC){1'b0}}, en_img};
            assign status_ext = {{(DATA_W-NUM_SRC){1'b0}}, status};
        end else begin : g_full
            assign img_ext    = en_img;
            assign status_ext = status;
        end
    endgenerate

    always_comb begin
        unique case (slot)
            SLOT_ENABLE: bus_rdata_o = img_ext;
            SLOT_STATUS: bus_rdata_o = status_ext;
            default:     bus_rdata_o = '0;
        endcase
    end

    logic [IDX_W-1:0] unused_idx;
    assign unused_idx = bus_addr_i[ADDR_W-1:2];

endmodule

// File: tb/sim_intagg_top.sv
`timescale 1ns/1ps
module sim_intagg_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic         wr = 1'b0;
    logic [3:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model state for the random phase
    logic [N-1:0] m_en, m_img, m_mask, m_st, m_pend;
    logic         m_irq, m_any;
    logic [31:0]  lfsr = 32'h1ACE_B00C;

    intagg_top #(.NUM_SRC(N), .DATA_W(N), .ADDR_W(4)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    always #4 clk = ~clk; // 125 MHz

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a negedge; reads both registers and the output.
    task automatic expect3(input string tag, input logic [N-1:0] img, input logic [N-1:0] st, input logic ir);
        addr = 4'd0; #1;
        chk({tag, " enable image"}, rdata, img);
        addr = 4'd4; #1;
        chk({tag, " status"}, rdata, st);
        chk({tag, " irq"}, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, ir});
        addr = 4'd0;
    endtask

    task automatic model_step(input logic [N-1:0] s, input logic w, input logic [3:0] a, input logic [N-1:0] d);
        logic [N-1:0] sel, ch, n_en, n_img, n_mask, n_st, n_pend;
        logic n_irq, any, trig;
        sel = s & m_en;
        any = |sel;
        trig = any && !m_any;
        n_en = m_en; n_img = m_img; n_mask = m_mask;
        n_st = m_st; n_pend = m_pend; n_irq = m_irq;
        if (w && a[3:2] == 2'd0) begin
            if (d == '0 && m_en == '0) n_img = d;
            else if ((m_en | d) != m_en) begin
                n_en = m_en | d; n_img = d;
            end else begin
                ch = m_img ^ d;
                if ((ch & d) != '0) n_mask = m_mask & ~ch;
                else n_mask = m_mask | ch;
                n_img = d;
            end
        end
        if (w && a[3:2] == 2'd1 && d != '0) begin
            n_st = m_st & ~d;
            if (d != {N{1'b1}} && n_st == '0) begin
                if (m_pend != '0) begin
                    n_st = m_pend; n_pend = '0; n_irq = 1'b1;
                end else n_irq = 1'b0;
            end
        end
        if (trig) begin
            if ((sel & (m_mask | m_st)) != '0) n_pend = n_pend | sel;
            else begin n_st = sel; n_irq = 1'b1; end
        end
        m_en = n_en; m_img = n_img; m_mask = n_mask;
        m_st = n_st; m_pend = n_pend; m_irq = n_irq; m_any = any;
    endtask

    // Called at a negedge; one clock with the given stimulus.
    task automatic step(input logic [N-1:0] s, input logic w, input logic [3:0] a, input logic [N-1:0] d);
        src = s; wr = w; addr = a; wdata = d;
        model_step(s, w, a, d);
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; addr = 4'd0; wdata = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; src = '0; wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_en = '0; m_img = '0; m_mask = '0; m_st = '0; m_pend = '0; m_irq = 1'b0; m_any = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        expect3("R1 reset", 8'h00, 8'h00, 1'b0);
        addr = 4'd8; #1; chk("R12 unmapped read", rdata, 8'h00); addr = 4'd0;

        step(8'h00, 1'b1, 4'd0, 8'h00); expect3("R5 zero enable", 8'h00, 8'h00, 1'b0);
        step(8'h00, 1'b1, 4'd0, 8'h0F); expect3("R6 add enables", 8'h0F, 8'h00, 1'b0);
        step(8'hF0, 1'b0, 4'd0, 8'h00); expect3("R2 disabled lines", 8'h0F, 8'h00, 1'b0);
        step(8'hF3, 1'b0, 4'd0, 8'h00); expect3("R3 first trigger", 8'h0F, 8'h03, 1'b1);
        step(8'hF3, 1'b0, 4'd0, 8'h00);
        step(8'hF3, 1'b0, 4'd0, 8'h00); expect3("R2 held line", 8'h0F, 8'h03, 1'b1);
        step(8'hF0, 1'b0, 4'd0, 8'h00);
        step(8'h04, 1'b0, 4'd0, 8'h00); expect3("R3 overwrite", 8'h0F, 8'h04, 1'b1);
        step(8'h00, 1'b0, 4'd0, 8'h00);
        step(8'h04, 1'b0, 4'd0, 8'h00); expect3("R4 blocked by status", 8'h0F, 8'h04, 1'b1);
        step(8'h04, 1'b1, 4'd4, 8'h00); expect3("R8 zero clear", 8'h0F, 8'h04, 1'b1);
        step(8'h04, 1'b1, 4'd4, 8'h04); expect3("R11 replay", 8'h0F, 8'h04, 1'b1);
        step(8'h00, 1'b1, 4'd4, 8'h04); expect3("R11 drain", 8'h0F, 8'h00, 1'b0);

        step(8'h00, 1'b1, 4'd0, 8'h0E); expect3("R7 mask bit0", 8'h0E, 8'h00, 1'b0);
        step(8'h01, 1'b0, 4'd0, 8'h00); expect3("R4 blocked by mask", 8'h0E, 8'h00, 1'b0);
        step(8'h01, 1'b1, 4'd0, 8'h0F); expect3("R7 unmask bit0", 8'h0F, 8'h00, 1'b0);
        step(8'h00, 1'b0, 4'd0, 8'h00);
        step(8'h01, 1'b0, 4'd0, 8'h00); expect3("R7 unmasked trigger", 8'h0F, 8'h01, 1'b1);
        step(8'h00, 1'b1, 4'd4, 8'h01); expect3("R11 replay masked", 8'h0F, 8'h01, 1'b1);
        step(8'h00, 1'b1, 4'd4, 8'h01); expect3("R11 drain again", 8'h0F, 8'h00, 1'b0);

        step(8'h02, 1'b0, 4'd0, 8'h00);
        step(8'h00, 1'b0, 4'd0, 8'h00);
        step(8'h02, 1'b0, 4'd0, 8'h00); expect3("R4 pend bit1", 8'h0F, 8'h02, 1'b1);
        step(8'h00, 1'b1, 4'd4, 8'hFF); expect3("R10 all ones", 8'h0F, 8'h00, 1'b1);
        step(8'h00, 1'b1, 4'd4, 8'h01); expect3("R10 pending kept", 8'h0F, 8'h02, 1'b1);
        step(8'h00, 1'b1, 4'd4, 8'h02); expect3("R11 final drain", 8'h0F, 8'h00, 1'b0);

        step(8'h0C, 1'b0, 4'd0, 8'h00); expect3("R3 two bits", 8'h0F, 8'h0C, 1'b1);
        step(8'h00, 1'b1, 4'd4, 8'h04); expect3("R9 partial clear", 8'h0F, 8'h08, 1'b1);
        step(8'h00, 1'b1, 4'd4, 8'h08); expect3("R9 last clear", 8'h0F, 8'h00, 1'b0);

        step(8'h00, 1'b1, 4'd8, 8'hFF);
        step(8'h00, 1'b1, 4'd12, 8'h55); expect3("R12 unmapped write", 8'h0F, 8'h00, 1'b0);
        addr = 4'd12; #1; chk("R12 unmapped read 12", rdata, 8'h00); addr = 4'd0;

        step(8'h01, 1'b1, 4'd4, 8'h20); expect3("R13 trigger wins", 8'h0F, 8'h01, 1'b1);
        step(8'h00, 1'b1, 4'd4, 8'h01); expect3("R13 drain", 8'h0F, 8'h00, 1'b0);

        step(8'h00, 1'b1, 4'd0, 8'h30); expect3("R6 sticky grow", 8'h30, 8'h00, 1'b0);
        step(8'h20, 1'b0, 4'd0, 8'h00); expect3("R6 new source", 8'h30, 8'h20, 1'b1);
        step(8'h00, 1'b0, 4'd0, 8'h00);
        step(8'h01, 1'b0, 4'd0, 8'h00); expect3("R6 old enable kept", 8'h30, 8'h01, 1'b1);
        step(8'h00, 1'b1, 4'd4, 8'h01); expect3("R6 drain", 8'h30, 8'h00, 1'b0);

        // random phase against the arithmetic model
        do_reset();
        expect3("R1 second reset", 8'h00, 8'h00, 1'b0);
        for (int i = 0; i < 4000; i++) begin
            logic [N-1:0] s, d;
            logic [3:0] a;
            logic w;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            s = src;
            w = 1'b0; a = 4'd0; d = lfsr[15:8];
            if (lfsr[2:0] < 3'd3) s = lfsr[23:16] & lfsr[31:24];
            if (lfsr[2:0] == 3'd3 || lfsr[2:0] == 3'd6) begin
                w = 1'b1; a = {lfsr[5:4], 2'b00};
                if (lfsr[4]) d = m_st & lfsr[15:8];
            end
            if (lfsr[2:0] == 3'd4) begin
                w = 1'b1; a = 4'd4;
                if (lfsr[6]) d = 8'hFF;
                else if (lfsr[7]) d = 8'h00;
                else d = m_st & lfsr[15:8];
            end
            if (lfsr[2:0] == 3'd5) begin
                w = 1'b1; a = 4'd0; d = m_img ^ (8'h01 << lfsr[10:8]);
            end
            step(s, w, a, d);
            expect3("R2 R3 R4 R7 R9 R11 R13 random", m_img, m_st, m_irq);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule